// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is a purely combinational 32-bit arithmetic and logic unit. It is built from one-bit slices, and a full-adder carry runs through every slice from the least to the most significant bit. Two operands and a 4-bit operation word go in. A 32-bit result comes out, together with a signed-overflow flag and an all-zero flag. The six named operations are AND, OR, add, subtract, set-on-less-than and NOR.

The 4-bit operation word is split into fields that act directly on the slices. Bit 3 inverts operand A. Bit 2 inverts operand B and also supplies the carry into bit 0. Bits 1:0 choose the slice output: 00 selects AND, 01 selects OR, 10 selects the sum and 11 selects the less input. Each ordinary slice takes a, b, less, both invert controls, a carry in and the 2-bit select. It returns a result bit and a carry out. The most significant slice is a separate variant that also produces the set signal and the overflow flag. The set signal is routed back to the less input of bit 0, and the less inputs of all other bits are tied low. Codes other than the six named ones behave as their field values dictate.

Top module: `alu32_ripple`

## Requirements
- R1: Code 0000 returns the bitwise AND of A and B.
- R2: Code 0001 returns the bitwise OR of A and B.
- R3: Code 0010 returns A+B modulo 2^32.
- R4: Code 0110 returns A-B modulo 2^32, computed as A + ~B + 1.
- R5: Code 0111 returns 1 in bit 0 when bit 31 of the raw A-B difference is 1, and 0 otherwise. This bit is not corrected for overflow. Bits 31:1 of the result are 0.
- R6: Code 1100 returns the bitwise NOR of A and B.
- R7: The zero output is 1 exactly when all 32 result bits are 0.
- R8: The overflow output is 1 when the carry into bit 31 differs from the carry out of bit 31. The adder always runs on the inverted-as-selected operands with the selected carry in, so this holds for every code.
- R9: For any code, bit 3 inverts A, bit 2 inverts B and sets the bit 0 carry in, and bits 1:0 pick AND (00), OR (01), sum (10) or less (11). For example, 1101 yields NAND and 0100 yields A AND NOT B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_ctrl | input | 4 | Operation word: invert-A, invert-B and carry in, and the 2-bit output select |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow out of the most significant slice |
| zero | output | 1 | High when the result is all zeros |

## Verification
The immediate assertions compare the slice chain against plain arithmetic and bitwise expressions. They assume the inputs carry only 0 and 1, because an X or Z value on an operand would make the comparisons meaningless. The bench therefore drives every operand and operation bit to a known value at all times, starting at time zero. It changes inputs only at falling clock edges, so each combinational check sees settled values. Stimulus covers the two required operand pairs under all six operations, together with overflow boundaries, equal operands and a sweep of all 16 codes over pseudo-random operands.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef enum logic [CTRL_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } op_e;

    typedef struct packed {
        logic inv_a;
        logic inv_b;
        logic carry0;
        sel_e sel;
    } slice_ctl_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    function automatic logic gate_and(input logic x, input logic y);
        return x & y;
    endfunction

    function automatic logic gate_or(input logic x, input logic y);
        return x | y;
    endfunction

    function automatic logic mux2(input logic d0, input logic d1, input logic s);
        return s ? d1 : d0;
    endfunction

    function automatic logic mux4(input logic d0, input logic d1,
                                  input logic d2, input logic d3, input sel_e s);
        logic r;
        case (s)
            SEL_AND:  r = d0;
            SEL_OR:   r = d1;
            SEL_SUM:  r = d2;
            default:  r = d3;
        endcase
        return r;
    endfunction

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t o;
        o.sum  = x ^ y ^ ci;
        o.cout = (x & y) | (x & ci) | (y & ci);
        return o;
    endfunction

endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
    import alu32_pkg::*;
(
    input  logic [CTRL_W-1:0] op_ctrl,
    output slice_ctl_t        ctl
);
    always_comb begin
        ctl.inv_a  = op_ctrl[3];
        ctl.inv_b  = op_ctrl[2];
        ctl.carry0 = op_ctrl[2];
        ctl.sel    = sel_e'(op_ctrl[1:0]);
    end
endmodule

// File: rtl/alu32_slice.sv
module alu32_slice
    import alu32_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic less,
    input  logic inv_a,
    input  logic inv_b,
    input  logic cin,
    input  sel_e sel,
    output logic res,
    output logic cout
);
    logic    a_eff, b_eff, p_and, p_or;
    fa_out_t fa;

    always_comb begin
        a_eff = mux2(a, ~a, inv_a);
        b_eff = mux2(b, ~b, inv_b);
        p_and = gate_and(a_eff, b_eff);
        p_or  = gate_or(a_eff, b_eff);
        fa    = full_add(a_eff, b_eff, cin);
        res   = mux4(p_and, p_or, fa.sum, less, sel);
        cout  = fa.cout;
    end
endmodule

// File: rtl/alu32_slice_msb.sv
module alu32_slice_msb
    import alu32_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic less,
    input  logic inv_a,
    input  logic inv_b,
    input  logic cin,
    input  sel_e sel,
    output logic res,
    output logic set,
    output logic ovf
);
    logic    a_eff, b_eff, p_and, p_or;
    fa_out_t fa;

    always_comb begin
        a_eff = mux2(a, ~a, inv_a);
        b_eff = mux2(b, ~b, inv_b);
        p_and = gate_and(a_eff, b_eff);
        p_or  = gate_or(a_eff, b_eff);
        fa    = full_add(a_eff, b_eff, cin);
        res   = mux4(p_and, p_or, fa.sum, less, sel);
        set   = fa.sum;
        ovf   = cin ^ fa.cout;
    end
endmodule

// File: rtl/alu32_zero.sv
module alu32_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] bits,
    output logic         all_zero
);
    always_comb all_zero = ~(|bits);
endmodule

// File: rtl/alu32_ripple.sv
module alu32_ripple
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [CTRL_W-1:0] op_ctrl,
    output logic [W-1:0]      result,
    output logic              ovf,
    output logic              zero
);
    localparam int MSB = W - 1;

    slice_ctl_t   ctl;
    logic [MSB:0] carry;
    logic [W-1:0] res_bits;
    logic         set_fb;

    alu32_decode u_dec (
        .op_ctrl (op_ctrl),
        .ctl     (ctl)
    );

    assign carry[0] = ctl.carry0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == MSB) begin : g_top
            alu32_slice_msb u_msb (
                .a     (opnd_a[i]),
                .b     (opnd_b[i]),
                .less  (1'b0),
                .inv_a (ctl.inv_a),
                .inv_b (ctl.inv_b),
                .cin   (carry[i]),
                .sel   (ctl.sel),
                .res   (res_bits[i]),
                .set   (set_fb),
                .ovf   (ovf)
            );
        end else begin : g_low
            alu32_slice u_bit (
                .a     (opnd_a[i]),
                .b     (opnd_b[i]),
                .less  ((i == 0) ? set_fb : 1'b0),
                .inv_a (ctl.inv_a),
                .inv_b (ctl.inv_b),
                .cin   (carry[i]),
                .sel   (ctl.sel),
                .res   (res_bits[i]),
                .cout  (carry[i+1])
            );
        end
    end

    assign result = res_bits;

    alu32_zero #(.W(W)) u_zero (
        .bits     (res_bits),
        .all_zero (zero)
    );

    always_comb begin
        if (op_ctrl == OP_AND)
            assert_and_R1: assert (result == (opnd_a & opnd_b));
        if (op_ctrl == OP_ADD)
            assert_add_R3: assert (result == opnd_a + opnd_b);
        if (op_ctrl == OP_SUB)
            assert_sub_R4: assert (result == opnd_a - opnd_b);
        if (op_ctrl == OP_SLT)
            assert_slt_upper_R5: assert (result[MSB:1] == '0);
        if (op_ctrl == OP_NOR)
            assert_nor_R6: assert (result == ~(opnd_a | opnd_b));
        if (op_ctrl == OP_ADD)
            assert_add_ovf_R8: assert (ovf == ((opnd_a[MSB] == opnd_b[MSB]) &&
                                               (result[MSB] != opnd_a[MSB])));
    end
endmodule

// File: tb/alu32_ripple_test.sv
module alu32_ripple_test;
    logic        clk = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  c = '0;
    logic [31:0] res;
    logic        ovf, zero;
    int          total = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    alu32_ripple uut (
        .opnd_a (a), .opnd_b (b), .op_ctrl (c),
        .result (res), .ovf (ovf), .zero (zero)
    );

    function automatic logic [32:0] model(input logic [3:0] k,
                                          input logic [31:0] x, input logic [31:0] y);
        logic [31:0] xa, yb, r;
        logic [32:0] s;
        logic        ov;
        xa = k[3] ? ~x : x;
        yb = k[2] ? ~y : y;
        s  = {1'b0, xa} + {1'b0, yb} + {32'd0, k[2]};
        ov = (xa[31] == yb[31]) && (s[31] != xa[31]);
        case (k[1:0])
            2'b00: r = xa & yb;
            2'b01: r = xa | yb;
            2'b10: r = s[31:0];
            default: r = {31'd0, s[31]};
        endcase
        return {ov, r};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] k, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        c = k; a = x; b = y;
        #1;
    endtask

    task automatic t_idle();
        #1;
        chk("R1 idle result", res, 32'd0);
        chk("R7 idle zero", {31'd0, zero}, 32'd1);
    endtask

    task automatic t_pair(input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] e_and, input logic [31:0] e_or,
                          input logic [31:0] e_add, input logic [31:0] e_sub,
                          input logic [31:0] e_slt, input logic [31:0] e_nor);
        apply(4'b0000, x, y); chk("R1 and", res, e_and);
        chk("R7 zero on and", {31'd0, zero}, {31'd0, e_and == 0});
        apply(4'b0001, x, y); chk("R2 or", res, e_or);
        apply(4'b0010, x, y); chk("R3 add", res, e_add);
        chk("R8 add ovf", {31'd0, ovf}, 32'd0);
        apply(4'b0110, x, y); chk("R4 sub", res, e_sub);
        apply(4'b0111, x, y); chk("R5 slt", res, e_slt);
        apply(4'b1100, x, y); chk("R6 nor", res, e_nor);
    endtask

    task automatic t_overflow();
        apply(4'b0010, 32'h7FFFFFFF, 32'h1);
        chk("R3 add wrap", res, 32'h80000000);
        chk("R8 add ovf pos", {31'd0, ovf}, 32'd1);
        apply(4'b0110, 32'h80000000, 32'h1);
        chk("R4 sub wrap", res, 32'h7FFFFFFF);
        chk("R8 sub ovf neg", {31'd0, ovf}, 32'd1);
        apply(4'b0111, 32'h80000000, 32'h1);
        chk("R5 slt raw sign under overflow", res, 32'd0);
        apply(4'b0010, 32'hFFFFFFFF, 32'h1);
        chk("R3 add carry out", res, 32'd0);
        chk("R8 no ovf on carry out", {31'd0, ovf}, 32'd0);
        chk("R7 zero after add", {31'd0, zero}, 32'd1);
    endtask

    task automatic t_equal();
        apply(4'b0110, 32'h12345678, 32'h12345678);
        chk("R4 sub equal", res, 32'd0);
        chk("R7 zero on equal", {31'd0, zero}, 32'd1);
        apply(4'b0111, 32'h12345678, 32'h12345678);
        chk("R5 slt equal", res, 32'd0);
        chk("R7 zero on slt false", {31'd0, zero}, 32'd1);
        apply(4'b0111, 32'h00000005, 32'h00000009);
        chk("R5 slt true", res, 32'd1);
        chk("R7 nonzero", {31'd0, zero}, 32'd0);
    endtask

    task automatic t_other_codes();
        apply(4'b1101, 32'hF0F0F0F0, 32'hFF00FF00);
        chk("R9 nand", res, ~(32'hF0F0F0F0 & 32'hFF00FF00));
        apply(4'b0100, 32'hF0F0F0F0, 32'hFF00FF00);
        chk("R9 and-not", res, 32'hF0F0F0F0 & ~32'hFF00FF00);
    endtask

    task automatic t_sweep();
        logic [32:0] e;
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] x, y;
                x = $urandom; y = $urandom;
                if (n < 4) begin x = {n[1], 31'h0}; y = {n[0], 31'h7FFFFFFF}; end
                apply(k[3:0], x, y);
                e = model(k[3:0], x, y);
                chk("R9 sweep result", res, e[31:0]);
                chk("R8 sweep ovf", {31'd0, ovf}, {31'd0, e[32]});
                chk("R7 sweep zero", {31'd0, zero}, {31'd0, e[31:0] == 0});
            end
        end
    endtask

    initial begin
        t_idle();
        t_pair(32'h3, 32'h4, 32'h0, 32'h7, 32'h7, 32'hFFFFFFFF, 32'h1, 32'hFFFFFFF8);
        t_pair(32'hFFFFFFB7, 32'h46, 32'h6, 32'hFFFFFFF7, 32'hFFFFFFFD,
               32'hFFFFFF71, 32'h1, 32'h8);
        t_overflow();
        t_equal();
        t_other_codes();
        t_sweep();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule